// File: doc/BRIEF.md
# Per-Timeslot Path Alarm Forcing Unit

This block sits in the receive path of a twelve-slot STS-12 style interface. It acts after pointer processing and overhead extraction. Each cycle it takes one byte tagged with its STS-1 slot number and a kind code. The kind code says whether the byte is the J1 trace byte, another path overhead byte, or payload.

For each slot, the block merges several inputs into one forced state:

- software force bits for loss of pointer (LOP) and for path AIS,
- a concatenation-mismatch check, which a per-slot mask bit can suppress,
- the LOP flag from the real pointer interpreter.

While a slot is in the forced state, the block rewrites that slot's bytes on their way downstream:

- The J1 byte is replaced by the last trace byte received while the slot was healthy.
- Every other overhead byte becomes zero.
- Payload bytes lose their valid qualifier.

The software controls for a slot are sampled only when that slot's own J1 byte arrives, so a frame is never partly forced. The pointer LOP flag and the concatenation state are live inputs. All outputs are registered one cycle after the input byte. The block has no transmit-side logic, so the transmitted path and its status byte are untouched by construction.

Top module: `path_alarm_force`

## Requirements
- R1: After reset, slot_lop and slot_ais are all 0 and out_valid is 0. The sampled controls reset to mask = 1 and both force bits = 0, so a concatenation mismatch raises no AIS until new controls are sampled.
- R2: When slot s receives a J1 byte (in_kind = 1) while cfg_force_lop[s] = 1, then from the next cycle slot_lop[s] = 1 and slot_ais[s] = 1, and the slot is forced.
- R3: When slot s receives a J1 byte while cfg_force_ais[s] = 1, then from the next cycle slot_ais[s] = 1 and the slot is forced.
- R4: Changes to cfg_force_lop, cfg_force_ais and cfg_mask for slot s take effect only at a J1 byte of slot s. A J1 byte of another slot, or any other byte, leaves the sampled controls of slot s unchanged.
- R5: A J1 byte of a forced slot is output as the most recent J1 byte that slot received while not forced (0 if there has been none since reset). A J1 byte of an unforced slot is stored for this purpose.
- R6: A path overhead byte (in_kind = 2) of a forced slot is output as 0, with out_valid still equal to the input valid.
- R7: A payload byte (in_kind = 0 or 3) of a forced slot is output with out_valid = 0 and out_byte = 0.
- R8: A byte of an unforced slot appears unchanged on out_byte, out_slot, out_kind and out_valid exactly one cycle after it is presented.
- R9: When a slot's sampled mask is 0 and concat_now[s] differs from concat_exp[s], slot_ais[s] = 1 on the next cycle. When the mask is 1, the mismatch raises no AIS.
- R10: The live pointer flag ptr_lop[s] is ORed into the LOP state: on the next cycle it sets slot_lop[s] and slot_ais[s] and forces the slot.
- R11: A byte with in_slot of 12 or more passes through unchanged and affects no slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte valid |
| in_slot | input | 4 | STS-1 slot number of the input byte |
| in_kind | input | 2 | 0 payload, 1 J1, 2 other path overhead, 3 treated as payload |
| in_byte | input | 8 | Input byte |
| ptr_lop | input | 12 | Live LOP flag per slot from pointer processing |
| concat_now | input | 12 | Current concatenation state per slot |
| concat_exp | input | 12 | Expected concatenation state per slot |
| cfg_force_lop | input | 12 | Software force-LOP bit per slot |
| cfg_force_ais | input | 12 | Software force-AIS bit per slot |
| cfg_mask | input | 12 | Per-slot mask that suppresses concatenation-mismatch AIS |
| out_valid | output | 1 | Output byte valid (cleared for payload of forced slots) |
| out_slot | output | 4 | Slot number of the output byte |
| out_kind | output | 2 | Kind code of the output byte |
| out_byte | output | 8 | Output byte after forcing |
| slot_lop | output | 12 | LOP indication per slot |
| slot_ais | output | 12 | Path AIS indication per slot |

## Verification
The bench raises a force bit in the middle of a frame and checks that nothing changes until that slot's next J1 byte. A design that applied controls at once would zero bytes in a partial frame. It also checks that a forced J1 byte carries the trace byte stored before the force. A design that kept updating the stored byte while forced, or that zeroed J1 along with the other overhead, would be caught.

Further tests cover the following:
- A concatenation mismatch before and after the mask is re-sampled, which exposes a reset mask of 0 or a mask that ignores the J1 timing.
- The live pointer LOP flag, which catches a design that leaves it out of the payload-drop decision.
- A slot number out of range, which must pass through untouched rather than alias onto slot 0.

// File: rtl/paf_pkg.sv
package paf_pkg;
    localparam int NSLOTS_DEF = 12;
    localparam int BYTE_W_DEF = 8;

    typedef enum logic [1:0] {
        KIND_PAYLOAD = 2'd0,
        KIND_J1      = 2'd1,
        KIND_POH     = 2'd2,
        KIND_SPARE   = 2'd3
    } oh_kind_e;

    typedef struct packed {
        logic force_lop;
        logic force_ais;
        logic mask;
    } slot_ctrl_t;

    localparam slot_ctrl_t CTRL_RESET = '{force_lop: 1'b0, force_ais: 1'b0, mask: 1'b1};

    // Any code other than J1 or overhead is handled as payload.
    function automatic logic is_payload(oh_kind_e k);
        return (k != KIND_J1) && (k != KIND_POH);
    endfunction

    // Combined alarm of one slot: LOP feeds AIS, and an unmasked concat mismatch adds to it.
    function automatic logic slot_alarm(logic lop, logic force_ais, logic mask,
                                        logic now_st, logic exp_st);
        return lop | force_ais | (~mask & (now_st ^ exp_st));
    endfunction
endpackage

// File: rtl/paf_ctrl_bank.sv
module paf_ctrl_bank
    import paf_pkg::*;
#(
    parameter int NSLOTS = NSLOTS_DEF,
    parameter int SLOT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              j1_hit,
    input  logic [SLOT_W-1:0] j1_slot,
    input  logic [NSLOTS-1:0] cfg_force_lop,
    input  logic [NSLOTS-1:0] cfg_force_ais,
    input  logic [NSLOTS-1:0] cfg_mask,
    output logic [NSLOTS-1:0] eff_lop,
    output logic [NSLOTS-1:0] eff_ais,
    output logic [NSLOTS-1:0] eff_mask
);
    for (genvar i = 0; i < NSLOTS; i++) begin : g_slot
        slot_ctrl_t ctrl_q;
        slot_ctrl_t ctrl_in;
        slot_ctrl_t ctrl_eff;
        logic       hit;

        assign hit      = j1_hit && (j1_slot == SLOT_W'(i));
        assign ctrl_in  = '{force_lop: cfg_force_lop[i], force_ais: cfg_force_ais[i], mask: cfg_mask[i]};
        // The J1 byte that opens a frame already uses the controls sampled with it.
        assign ctrl_eff = hit ? ctrl_in : ctrl_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                ctrl_q <= CTRL_RESET;
            end else if (hit) begin
                ctrl_q <= ctrl_in;
            end
        end

        assign eff_lop[i]  = ctrl_eff.force_lop;
        assign eff_ais[i]  = ctrl_eff.force_ais;
        assign eff_mask[i] = ctrl_eff.mask;
    end
endmodule

// File: rtl/paf_alarm_merge.sv
module paf_alarm_merge
    import paf_pkg::*;
#(
    parameter int NSLOTS = NSLOTS_DEF
) (
    input  logic [NSLOTS-1:0] eff_lop,
    input  logic [NSLOTS-1:0] eff_ais,
    input  logic [NSLOTS-1:0] eff_mask,
    input  logic [NSLOTS-1:0] ptr_lop,
    input  logic [NSLOTS-1:0] concat_now,
    input  logic [NSLOTS-1:0] concat_exp,
    output logic [NSLOTS-1:0] lop_c,
    output logic [NSLOTS-1:0] ais_c
);
    for (genvar i = 0; i < NSLOTS; i++) begin : g_merge
        assign lop_c[i] = eff_lop[i] | ptr_lop[i];
        assign ais_c[i] = slot_alarm(lop_c[i], eff_ais[i], eff_mask[i],
                                     concat_now[i], concat_exp[i]);
    end
endmodule

// File: rtl/paf_j1_store.sv
module paf_j1_store
    import paf_pkg::*;
#(
    parameter int NSLOTS = NSLOTS_DEF,
    parameter int SLOT_W = 4,
    parameter int BYTE_W = BYTE_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic [BYTE_W-1:0] rd_byte
);
    logic [BYTE_W-1:0] held [NSLOTS];

    for (genvar i = 0; i < NSLOTS; i++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst) begin
                held[i] <= '0;
            end else if (wr_en && (wr_slot == SLOT_W'(i))) begin
                held[i] <= wr_byte;
            end
        end
    end

    assign rd_byte = held[rd_slot];
endmodule

// File: rtl/path_alarm_force.sv
module path_alarm_force
    import paf_pkg::*;
#(
    parameter int NSLOTS = NSLOTS_DEF,
    parameter int BYTE_W = BYTE_W_DEF
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        in_valid,
    input  logic [$clog2(NSLOTS+1)-1:0] in_slot,
    input  logic [1:0]                  in_kind,
    input  logic [BYTE_W-1:0]           in_byte,
    input  logic [NSLOTS-1:0]           ptr_lop,
    input  logic [NSLOTS-1:0]           concat_now,
    input  logic [NSLOTS-1:0]           concat_exp,
    input  logic [NSLOTS-1:0]           cfg_force_lop,
    input  logic [NSLOTS-1:0]           cfg_force_ais,
    input  logic [NSLOTS-1:0]           cfg_mask,
    output logic                        out_valid,
    output logic [$clog2(NSLOTS+1)-1:0] out_slot,
    output logic [1:0]                  out_kind,
    output logic [BYTE_W-1:0]           out_byte,
    output logic [NSLOTS-1:0]           slot_lop,
    output logic [NSLOTS-1:0]           slot_ais
);
    localparam int SLOT_W = $clog2(NSLOTS + 1);

    oh_kind_e          kind;
    logic              slot_ok;
    logic [SLOT_W-1:0] idx;
    logic              j1_hit;
    logic              forced;
    logic              j1_wr;
    logic [BYTE_W-1:0] held_j1;
    logic [NSLOTS-1:0] eff_lop, eff_ais, eff_mask;
    logic [NSLOTS-1:0] lop_c, ais_c;
    logic              nxt_valid;
    logic [BYTE_W-1:0] nxt_byte;

    assign kind    = oh_kind_e'(in_kind);
    assign slot_ok = (in_slot < SLOT_W'(NSLOTS));
    assign idx     = slot_ok ? in_slot : '0;
    assign j1_hit  = in_valid && slot_ok && (kind == KIND_J1);

    paf_ctrl_bank #(.NSLOTS(NSLOTS), .SLOT_W(SLOT_W)) u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .j1_hit        (j1_hit),
        .j1_slot       (idx),
        .cfg_force_lop (cfg_force_lop),
        .cfg_force_ais (cfg_force_ais),
        .cfg_mask      (cfg_mask),
        .eff_lop       (eff_lop),
        .eff_ais       (eff_ais),
        .eff_mask      (eff_mask)
    );

    paf_alarm_merge #(.NSLOTS(NSLOTS)) u_merge (
        .eff_lop    (eff_lop),
        .eff_ais    (eff_ais),
        .eff_mask   (eff_mask),
        .ptr_lop    (ptr_lop),
        .concat_now (concat_now),
        .concat_exp (concat_exp),
        .lop_c      (lop_c),
        .ais_c      (ais_c)
    );

    assign forced = slot_ok && ais_c[idx];
    // Only a trace byte seen while healthy becomes the value replayed later.
    assign j1_wr  = j1_hit && !forced;

    paf_j1_store #(.NSLOTS(NSLOTS), .SLOT_W(SLOT_W), .BYTE_W(BYTE_W)) u_j1 (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (j1_wr),
        .wr_slot (idx),
        .wr_byte (in_byte),
        .rd_slot (idx),
        .rd_byte (held_j1)
    );

    always_comb begin
        nxt_valid = in_valid;
        nxt_byte  = in_byte;
        if (forced) begin
            if (kind == KIND_J1) begin
                nxt_byte = held_j1;
            end else if (kind == KIND_POH) begin
                nxt_byte = '0;
            end else begin
                nxt_byte  = '0;
                nxt_valid = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_slot  <= '0;
            out_kind  <= '0;
            out_byte  <= '0;
            slot_lop  <= '0;
            slot_ais  <= '0;
        end else begin
            out_valid <= nxt_valid;
            out_slot  <= in_slot;
            out_kind  <= in_kind;
            out_byte  <= nxt_byte;
            slot_lop  <= lop_c;
            slot_ais  <= ais_c;
        end
    end

    // R1: the first cycle out of reset shows no alarm and no data
    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (slot_lop == '0) && (slot_ais == '0) && !out_valid);

    // R6: overhead of a slot flagged AIS leaves as zero
    p_poh_zeroed_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_kind == 2'd2 && out_slot < SLOT_W'(NSLOTS) && slot_ais[out_slot])
        |-> (out_byte == '0));

    // R7: payload of a slot flagged AIS is never marked valid
    p_payload_dropped_r7: assert property (@(posedge clk) disable iff (rst)
        (out_kind != 2'd1 && out_kind != 2'd2 && out_slot < SLOT_W'(NSLOTS) && slot_ais[out_slot])
        |-> !out_valid);

    // R8: output valid and slot follow the input one cycle later
    p_one_cycle_r8: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (out_slot == $past(in_slot)) && (!out_valid || $past(in_valid)));

    // R10: a live pointer LOP always shows up as LOP and AIS
    p_ptr_lop_r10: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (($past(ptr_lop) & ~(slot_lop & slot_ais)) == '0));
endmodule

// File: tb/path_alarm_force_tb.sv
module path_alarm_force_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [3:0]  in_slot = '0;
    logic [1:0]  in_kind = '0;
    logic [7:0]  in_byte = '0;
    logic [11:0] ptr_lop = '0;
    logic [11:0] concat_now = '0;
    logic [11:0] concat_exp = '0;
    logic [11:0] cfg_force_lop = '0;
    logic [11:0] cfg_force_ais = '0;
    logic [11:0] cfg_mask = '1;
    logic        out_valid;
    logic [3:0]  out_slot;
    logic [1:0]  out_kind;
    logic [7:0]  out_byte;
    logic [11:0] slot_lop;
    logic [11:0] slot_ais;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    path_alarm_force u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_slot(in_slot),
        .in_kind(in_kind), .in_byte(in_byte), .ptr_lop(ptr_lop),
        .concat_now(concat_now), .concat_exp(concat_exp),
        .cfg_force_lop(cfg_force_lop), .cfg_force_ais(cfg_force_ais),
        .cfg_mask(cfg_mask), .out_valid(out_valid), .out_slot(out_slot),
        .out_kind(out_kind), .out_byte(out_byte), .slot_lop(slot_lop),
        .slot_ais(slot_ais)
    );

    // Vector: slot, kind, byte, force_lop, force_ais -> exp valid, exp byte, exp slot_ais[slot]
    localparam int NV = 13;
    localparam logic [25:0] VEC [NV] = '{
        {4'd3, 2'd1, 8'h5A, 1'b0, 1'b0, 1'b1, 8'h5A, 1'b0}, // R8 unforced J1 stored
        {4'd3, 2'd2, 8'h77, 1'b0, 1'b0, 1'b1, 8'h77, 1'b0}, // R8
        {4'd3, 2'd0, 8'hC3, 1'b0, 1'b0, 1'b1, 8'hC3, 1'b0}, // R8
        {4'd3, 2'd0, 8'h44, 1'b0, 1'b1, 1'b1, 8'h44, 1'b0}, // R4 mid-frame change ignored
        {4'd3, 2'd1, 8'h99, 1'b0, 1'b1, 1'b1, 8'h5A, 1'b1}, // R3 R5 forced J1 replays 5A
        {4'd3, 2'd2, 8'h66, 1'b0, 1'b0, 1'b1, 8'h00, 1'b1}, // R6 and R4
        {4'd3, 2'd0, 8'hAB, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1}, // R7
        {4'd7, 2'd1, 8'h21, 1'b1, 1'b0, 1'b1, 8'h00, 1'b1}, // R2 R5 nothing stored yet
        {4'd7, 2'd3, 8'h13, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1}, // R7 spare code is payload
        {4'd3, 2'd1, 8'h3C, 1'b0, 1'b0, 1'b1, 8'h3C, 1'b0}, // R8 released, J1 stored
        {4'd3, 2'd0, 8'hE1, 1'b0, 1'b0, 1'b1, 8'hE1, 1'b0}, // R8
        {4'd7, 2'd1, 8'h42, 1'b0, 1'b0, 1'b1, 8'h42, 1'b0}, // R8
        {4'd7, 2'd2, 8'h81, 1'b0, 1'b0, 1'b1, 8'h81, 1'b0}  // R8
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [3:0] s, input logic [1:0] k, input logic [7:0] b);
        in_valid = v;
        in_slot  = s;
        in_kind  = k;
        in_byte  = b;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    initial begin
        repeat (3) step();
        concat_now = 12'hFFF;   // mismatch on every slot, mask still at reset value
        cfg_mask   = '0;        // not sampled without J1
        rst = 1'b0;
        step();
        step();
        check("R1 slot_lop", 32'(slot_lop), 32'h0);
        check("R1 slot_ais masked", 32'(slot_ais), 32'h0);
        check("R1 out_valid", 32'(out_valid), 32'h0);
        concat_now = '0;
        cfg_mask   = '1;

        for (int i = 0; i < NV; i++) begin
            logic [25:0] v;
            v = VEC[i];
            drive(1'b1, v[25:22], v[21:20], v[19:12]);
            cfg_force_lop = 12'(v[11]) << v[25:22];
            cfg_force_ais = 12'(v[10]) << v[25:22];
            step();
            check($sformatf("R8 vec%0d valid", i), 32'(out_valid), 32'(v[9]));
            check($sformatf("R5 R6 R7 vec%0d byte", i), 32'(out_byte), 32'(v[8:1]));
            check($sformatf("R2 R3 vec%0d ais", i), 32'(slot_ais[v[25:22]]), 32'(v[0]));
            if (i == 7) check("R2 slot_lop", 32'(slot_lop), 32'h080);
            if (i == 4) check("R3 lop clear", 32'(slot_lop), 32'h0);
        end
        cfg_force_lop = '0;
        cfg_force_ais = '0;

        // R9: clear the mask of slot 2 at its J1, then present a mismatch
        cfg_mask = 12'hFFB;
        drive(1'b1, 4'd2, 2'd1, 8'h10);
        step();
        check("R9 no mismatch yet", 32'(slot_ais[2]), 32'h0);
        drive(1'b0, 4'd0, 2'd0, 8'h00);
        concat_now = 12'h024;   // slots 2 and 5 differ
        step();
        check("R9 unmasked mismatch", 32'(slot_ais[2]), 32'h1);
        check("R9 masked slot 5", 32'(slot_ais[5]), 32'h0);
        check("R4 mask of slot 5 untouched", 32'(slot_ais), 32'h004);
        concat_now = '0;
        step();
        check("R9 mismatch gone", 32'(slot_ais), 32'h0);

        // R10: live pointer LOP on slot 9
        ptr_lop = 12'h200;
        drive(1'b1, 4'd9, 2'd0, 8'h77);
        step();
        check("R10 slot_lop", 32'(slot_lop), 32'h200);
        check("R10 slot_ais", 32'(slot_ais), 32'h200);
        check("R10 payload dropped", 32'(out_valid), 32'h0);
        ptr_lop = '0;
        drive(1'b1, 4'd9, 2'd0, 8'h78);
        step();
        check("R10 released", 32'({out_valid, out_byte, slot_lop}), 32'({1'b1, 8'h78, 12'h0}));

        // R11: out-of-range slot passes through and leaves slot 0 alone
        cfg_force_ais = '1;
        drive(1'b1, 4'd13, 2'd1, 8'h5E);
        step();
        check("R11 passthrough", 32'({out_valid, out_slot, out_byte}), 32'({1'b1, 4'd13, 8'h5E}));
        check("R11 no slot hit", 32'(slot_ais), 32'h0);
        drive(1'b1, 4'd0, 2'd0, 8'hA5);
        cfg_force_ais = '0;
        step();
        check("R11 slot 0 unaffected", 32'({out_valid, out_byte}), 32'({1'b1, 8'hA5}));
        drive(1'b0, 4'd0, 2'd0, 8'h00);
        step();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule